// File: doc/BRIEF.md
# Interrupt Request Output Controller

This block collects a set of interrupt event strobes into sticky status bits, qualifies them with per-source enable bits, and drives a single external interrupt request pin. When the set of enabled, uncleared status bits goes from empty to non-empty, the pin is asserted for a programmable number of reference-clock periods. In a latched mode it is instead held for as long as any enabled status bit remains set. A software stimulus bit forces the pin active at any time.

One status source carries copy-protection detection. A two-bit select decides whether that source is fed by pseudo-sync pulse detections, by colour-stripe detections, by either, or by neither. The pin is modelled as an output enable plus a data value, with three drive styles: open drain, active-low push-pull and active-high push-pull. The reset state is open drain with every source disabled, so the pin floats until software changes the configuration.

A small register port configures the block. Address 0 holds the configuration, address 1 holds the source enables, and address 2 holds the status bits, which are cleared by writing ones. Reads are combinational from the address.

Top module: `irq_request_ctl`

## Requirements
- R1: After reset, address 0 reads 0x10: pulse length code 00 in bits [7:6], copy-protection select 01 in bits [5:4], bit 3 zero, stimulus bit 2 zero, and drive mode 00 in bits [1:0]. Addresses 1 and 2 read 0, and irq_oe is 0.
- R2: A one-cycle strobe on a source sets its status bit (bit i of address 2) from the next clock onwards. Writing 1 to that bit clears it. Writing 0 leaves it set.
- R3: If a strobe and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: The copy-protection source (status bit 3 by default) is set by cp_psync_evt when the select is 01, by cp_stripe_evt when it is 10, by either when it is 11, and by neither when it is 00.
- R5: With pulse length code 00, 01 or 10, the request is active for exactly 3, 15 or 63 clocks. It becomes active one clock after the enabled status bit becomes readable.
- R6: While the OR of (status AND enable) stays non-zero, further events start no new pulse. A new pulse starts only after that OR has returned to zero and then risen again.
- R7: With length code 11, the request is active for exactly as long as some enabled status bit is set. It drops as soon as that bit is cleared or its enable bit is written to 0.
- R8: Setting the stimulus bit (bit 2 of address 0) makes the request active regardless of status and enables.
- R9: Drive mode 00 gives irq_oe equal to active and irq_out 0. Mode 01 gives irq_oe 1 and irq_out equal to NOT active. Mode 10 gives irq_oe 1 and irq_out equal to active. Mode 11 gives irq_oe 0 and irq_out 0.
- R10: A source whose enable bit (bit i of address 1) is 0 still sets its status bit but never activates the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NUM_SRC-1 | One-cycle event strobes for the ordinary sources |
| cp_psync_evt | input | 1 | Pseudo-sync detection strobe |
| cp_stripe_evt | input | 1 | Colour-stripe detection strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_oe | output | 1 | Pin output enable |
| irq_out | output | 1 | Pin data value |

## Verification
Two functions can land in the same clock: a source strobe and a write-one-to-clear of the same status bit. The bench raises both in one cycle and then reads the status register to confirm that the set wins. The second collision is a new event that arrives while an earlier enabled event is still pending. The bench provokes it by strobing a second enabled source after the first pulse has ended. It then counts pin-active cycles to confirm that no extra pulse appears, and that a pulse does appear once both bits have been cleared.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   localparam int REG_W = 8;

   localparam int ADDR_CFG  = 0;
   localparam int ADDR_MASK = 1;
   localparam int ADDR_STAT = 2;

   localparam int DUR_MSB  = 7;
   localparam int DUR_LSB  = 6;
   localparam int CPS_MSB  = 5;
   localparam int CPS_LSB  = 4;
   localparam int STIM_BIT = 2;
   localparam int DRV_MSB  = 1;
   localparam int DRV_LSB  = 0;

   typedef enum logic [1:0] {
      DUR_SHORT = 2'b00,
      DUR_MED   = 2'b01,
      DUR_LONG  = 2'b10,
      DUR_LATCH = 2'b11
   } dur_e;

   typedef enum logic [1:0] {
      DRV_OPEN_DRAIN = 2'b00,
      DRV_LOW_ACT    = 2'b01,
      DRV_HIGH_ACT   = 2'b10,
      DRV_RSVD       = 2'b11
   } drv_e;

   typedef enum logic [1:0] {
      CP_NONE   = 2'b00,
      CP_PSYNC  = 2'b01,
      CP_STRIPE = 2'b10,
      CP_EITHER = 2'b11
   } cpsel_e;

   typedef struct packed {
      dur_e   dur;
      cpsel_e cp;
      logic   stim;
      drv_e   drv;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{dur: DUR_SHORT, cp: CP_PSYNC, stim: 1'b0, drv: DRV_OPEN_DRAIN};

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_ctl_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [NUM_SRC-1:0] status_i,
   output cfg_t               cfg_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [REG_W-1:0]   rdata_o
);

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADDR_CFG);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(ADDR_MASK);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

   generate
      if (NUM_SRC > REG_W) begin : g_bad_width
         $error("irq_cfg_regs: NUM_SRC must not exceed the register width");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("irq_cfg_regs: ADDR_W must be at least 2");
      end
   endgenerate

   cfg_t               cfg_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               hit_cfg, hit_mask, hit_stat;

   assign hit_cfg  = wr_i && (addr_i == A_CFG);
   assign hit_mask = wr_i && (addr_i == A_MASK);
   assign hit_stat = wr_i && (addr_i == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RESET;
         mask_q <= '0;
      end else begin
         if (hit_cfg) begin
            cfg_q.dur  <= dur_e'(wdata_i[DUR_MSB:DUR_LSB]);
            cfg_q.cp   <= cpsel_e'(wdata_i[CPS_MSB:CPS_LSB]);
            cfg_q.stim <= wdata_i[STIM_BIT];
            cfg_q.drv  <= drv_e'(wdata_i[DRV_MSB:DRV_LSB]);
         end
         if (hit_mask) begin
            mask_q <= wdata_i[NUM_SRC-1:0];
         end
      end
   end

   assign clr_o  = hit_stat ? wdata_i[NUM_SRC-1:0] : '0;
   assign cfg_o  = cfg_q;
   assign mask_o = mask_q;

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         A_CFG: begin
            rdata_o[DUR_MSB:DUR_LSB] = cfg_q.dur;
            rdata_o[CPS_MSB:CPS_LSB] = cfg_q.cp;
            rdata_o[STIM_BIT]        = cfg_q.stim;
            rdata_o[DRV_MSB:DRV_LSB] = cfg_q.drv;
         end
         A_MASK:  rdata_o = REG_W'(mask_q);
         A_STAT:  rdata_o = REG_W'(status_i);
         default: rdata_o = '0;
      endcase
   end

   logic unused_wbits;
   assign unused_wbits = ^{1'b0, wdata_i[3]};

   // R9: a write to the drive field takes effect on the next clock
   a_r9_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cfg |=> (cfg_q.drv == drv_e'($past(wdata_i[DRV_MSB:DRV_LSB]))));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
   import irq_ctl_pkg::*;
#(
   parameter int NUM_SRC = 4,
   parameter int CP_SRC  = NUM_SRC - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-2:0] evt_i,
   input  logic               psync_i,
   input  logic               stripe_i,
   input  cpsel_e             cp_sel_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] status_o
);

   generate
      if (NUM_SRC < 2) begin : g_bad_num
         $error("irq_status_bank: NUM_SRC must be at least 2");
      end
      if (CP_SRC < 0 || CP_SRC >= NUM_SRC) begin : g_bad_cp
         $error("irq_status_bank: CP_SRC out of range");
      end
   endgenerate

   logic [NUM_SRC-1:0] set_w;
   logic               cp_hit;

   assign cp_hit = (cp_sel_i[0] & psync_i) | (cp_sel_i[1] & stripe_i);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
         if (gi == CP_SRC) begin : g_cp
            assign set_w[gi] = cp_hit;
         end else if (gi < CP_SRC) begin : g_lo
            assign set_w[gi] = evt_i[gi];
         end else begin : g_hi
            assign set_w[gi] = evt_i[gi-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status_o[gi] <= 1'b0;
            end else if (set_w[gi]) begin
               status_o[gi] <= 1'b1;
            end else if (clr_i[gi]) begin
               status_o[gi] <= 1'b0;
            end
         end

         // R3: an event in the same cycle as a clear leaves the bit set
         a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_w[gi] |=> status_o[gi]);

         // R2: a set bit holds until a clear arrives
         a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[gi] && !clr_i[gi]) |=> status_o[gi]);

         // R2: a clear without an event empties the bit
         a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[gi] && !set_w[gi]) |=> !status_o[gi]);
      end
   endgenerate

   // R4: with select 00 the copy-protection bit can only fall or hold
   a_r4_cp_none: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_sel_i == CP_NONE && !status_o[CP_SRC]) |=> !status_o[CP_SRC]);

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer
   import irq_ctl_pkg::*;
#(
   parameter int SHORT_LEN = 3,
   parameter int MED_LEN   = 15,
   parameter int LONG_LEN  = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   input  dur_e dur_i,
   output logic active_o
);

   localparam int CNT_W = $clog2(LONG_LEN + 1);

   generate
      if (SHORT_LEN < 1) begin : g_bad_short
         $error("irq_pulse_timer: SHORT_LEN must be positive");
      end
      if (MED_LEN < SHORT_LEN || LONG_LEN < MED_LEN) begin : g_bad_order
         $error("irq_pulse_timer: lengths must not decrease");
      end
   endgenerate

   logic             pend_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_w;
   logic             latched, start;

   assign latched = (dur_i == DUR_LATCH);
   assign start   = pend_i && !pend_q;

   always_comb begin
      unique case (dur_i)
         DUR_SHORT: load_w = CNT_W'(SHORT_LEN);
         DUR_MED:   load_w = CNT_W'(MED_LEN);
         DUR_LONG:  load_w = CNT_W'(LONG_LEN);
         default:   load_w = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         pend_q <= pend_i;
         if (start && !latched) begin
            cnt_q <= load_w;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign active_o = latched ? pend_i : (cnt_q != '0);

   // R5: a running count steps down by one each clock
   a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R5: a rising pending level in a timed mode starts a pulse
   a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !latched) |=> (cnt_q != '0));

   // R6: a pending level that persists restarts nothing
   a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i && pend_q && !latched && cnt_q == '0) |=> (cnt_q == '0 || !pend_q));

endmodule

// File: rtl/irq_pin_driver.sv
module irq_pin_driver
   import irq_ctl_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  drv_e drv_i,
   output logic oe_o,
   output logic dat_o
);

   logic oe_w, dat_w;

   always_comb begin
      unique case (drv_i)
         DRV_OPEN_DRAIN: begin oe_w = active_i; dat_w = 1'b0;      end
         DRV_LOW_ACT:    begin oe_w = 1'b1;     dat_w = !active_i; end
         DRV_HIGH_ACT:   begin oe_w = 1'b1;     dat_w = active_i;  end
         default:        begin oe_w = 1'b0;     dat_w = 1'b0;      end
      endcase
   end

   generate
      if (REG_OUT) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               oe_o  <= 1'b0;
               dat_o <= 1'b0;
            end else begin
               oe_o  <= oe_w;
               dat_o <= dat_w;
            end
         end

         // R9: the reserved mode floats the pin
         a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_i == DRV_RSVD) |=> !oe_o);
      end else begin : g_comb
         assign oe_o  = oe_w;
         assign dat_o = dat_w;

         // R9: the reserved mode floats the pin
         a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_i == DRV_RSVD) |-> !oe_o);

         // R9: the open-drain mode only ever pulls low
         a_r9_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
            (drv_i == DRV_OPEN_DRAIN) |-> !dat_o);
      end
   endgenerate

endmodule

// File: rtl/irq_request_ctl.sv
module irq_request_ctl
   import irq_ctl_pkg::*;
#(
   parameter int NUM_SRC   = 4,
   parameter int CP_SRC    = NUM_SRC - 1,
   parameter int ADDR_W    = 2,
   parameter int SHORT_LEN = 3,
   parameter int MED_LEN   = 15,
   parameter int LONG_LEN  = 63,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-2:0] evt_strobe,
   input  logic               cp_psync_evt,
   input  logic               cp_stripe_evt,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               irq_oe,
   output logic               irq_out
);

   cfg_t               cfg;
   logic [NUM_SRC-1:0] mask, clr, status;
   logic               pend, timed_active, req_active;

   irq_cfg_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (reg_wr),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .status_i (status),
      .cfg_o    (cfg),
      .mask_o   (mask),
      .clr_o    (clr),
      .rdata_o  (reg_rdata)
   );

   irq_status_bank #(.NUM_SRC(NUM_SRC), .CP_SRC(CP_SRC)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_strobe),
      .psync_i  (cp_psync_evt),
      .stripe_i (cp_stripe_evt),
      .cp_sel_i (cfg.cp),
      .clr_i    (clr),
      .status_o (status)
   );

   assign pend = |(status & mask);

   irq_pulse_timer #(.SHORT_LEN(SHORT_LEN), .MED_LEN(MED_LEN), .LONG_LEN(LONG_LEN)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_i   (pend),
      .dur_i    (cfg.dur),
      .active_o (timed_active)
   );

   assign req_active = timed_active | cfg.stim;

   irq_pin_driver #(.REG_OUT(REG_OUT)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (req_active),
      .drv_i    (cfg.drv),
      .oe_o     (irq_oe),
      .dat_o    (irq_out)
   );

   // R7: latched mode follows the enabled status bits
   a_r7_latched_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.dur == DUR_LATCH && !cfg.stim) |-> (req_active == |(status & mask)));

   // R8: the stimulus bit drives an active-high pin high
   a_r8_stim: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.stim && cfg.drv == DRV_HIGH_ACT && !REG_OUT) |-> (irq_oe && irq_out));

   // R10: no enabled status and no stimulus keeps latched mode idle
   a_r10_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.dur == DUR_LATCH && !cfg.stim && (status & mask) == '0) |-> !req_active);

endmodule

// File: tb/tb_irq_request_ctl.sv
module tb_irq_request_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] evt_strobe = '0;
   logic       cp_psync_evt = 1'b0;
   logic       cp_stripe_evt = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq_oe, irq_out;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_request_ctl dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .evt_strobe    (evt_strobe),
      .cp_psync_evt  (cp_psync_evt),
      .cp_stripe_evt (cp_stripe_evt),
      .reg_wr        (reg_wr),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .irq_oe        (irq_oe),
      .irq_out       (irq_out)
   );

   // {length code, expected active cycles}
   localparam logic [9:0] PULSE_TAB [3] = '{ {2'b00, 8'd3}, {2'b01, 8'd15}, {2'b10, 8'd63} };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic strobe(input logic [2:0] ev, input logic ps, input logic cs);
      @(negedge clk);
      evt_strobe = ev; cp_psync_evt = ps; cp_stripe_evt = cs;
      @(negedge clk);
      evt_strobe = '0; cp_psync_evt = 1'b0; cp_stripe_evt = 1'b0;
   endtask

   // count cycles with the pin high (drive mode 10) and the index of the first
   task automatic measure(input int n, output int width, output int first);
      width = 0; first = -1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (irq_oe && irq_out) begin
            if (first < 0) first = i;
            width++;
         end
      end
   endtask

   function automatic logic [7:0] cfgb(input logic [1:0] dur, input logic [1:0] cp,
                                       input logic stim, input logic [1:0] drv);
      return {dur, cp, 1'b0, stim, drv};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      int w, f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, d); check("R1 cfg", d, 8'h10);
      rd(2'd1, d); check("R1 mask", d, 0);
      rd(2'd2, d); check("R1 status", d, 0);
      check("R1 oe", irq_oe, 0);

      // R5 pulse lengths from table
      wr(2'd1, 8'h01);
      foreach (PULSE_TAB[k]) begin
         wr(2'd0, cfgb(PULSE_TAB[k][9:8], 2'b01, 1'b0, 2'b10));
         strobe(3'b001, 1'b0, 1'b0);
         measure(80, w, f);
         check("R5 width", w, int'(PULSE_TAB[k][7:0]));
         check("R5 start", f, 0);
         wr(2'd2, 8'h0F);
      end

      // R6 no new pulse while pending
      wr(2'd0, cfgb(2'b00, 2'b01, 1'b0, 2'b10));
      wr(2'd1, 8'h03);
      strobe(3'b001, 1'b0, 1'b0);
      measure(10, w, f);
      check("R6 first pulse", w, 3);
      strobe(3'b010, 1'b0, 1'b0);
      measure(20, w, f);
      check("R6 no retrigger", w, 0);
      wr(2'd2, 8'h03);
      strobe(3'b010, 1'b0, 1'b0);
      measure(10, w, f);
      check("R6 retrigger after clear", w, 3);
      wr(2'd2, 8'h0F);

      // R7 latched mode, cleared then masked
      wr(2'd0, cfgb(2'b11, 2'b01, 1'b0, 2'b10));
      wr(2'd1, 8'h01);
      strobe(3'b001, 1'b0, 1'b0);
      measure(30, w, f);
      check("R7 held", w, 30);
      wr(2'd2, 8'h01);
      check("R7 drop on clear", irq_out, 0);
      strobe(3'b001, 1'b0, 1'b0);
      check("R7 set again", irq_out, 1);
      wr(2'd1, 8'h00);
      check("R7 drop on mask", irq_out, 0);
      wr(2'd2, 8'h0F);

      // R2 write-one-to-clear
      strobe(3'b100, 1'b0, 1'b0);
      rd(2'd2, d); check("R2 set", d, 8'h04);
      wr(2'd2, 8'h00);
      rd(2'd2, d); check("R2 zero write keeps", d, 8'h04);
      wr(2'd2, 8'h04);
      rd(2'd2, d); check("R2 cleared", d, 0);

      // R3 set and clear in one cycle
      strobe(3'b001, 1'b0, 1'b0);
      @(negedge clk);
      evt_strobe = 3'b001; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
      @(negedge clk);
      evt_strobe = '0; reg_wr = 1'b0;
      rd(2'd2, d); check("R3 set wins", d, 8'h01);
      wr(2'd2, 8'h0F);

      // R4 copy-protection select
      for (int s = 0; s < 4; s++) begin
         wr(2'd0, cfgb(2'b00, 2'(s), 1'b0, 2'b10));
         strobe(3'b000, 1'b1, 1'b0);
         rd(2'd2, d); check("R4 psync", d[3], s & 1);
         wr(2'd2, 8'h0F);
         strobe(3'b000, 1'b0, 1'b1);
         rd(2'd2, d); check("R4 stripe", d[3], (s >> 1) & 1);
         wr(2'd2, 8'h0F);
      end

      // R10 masked source
      wr(2'd0, cfgb(2'b11, 2'b01, 1'b0, 2'b10));
      wr(2'd1, 8'h01);
      strobe(3'b100, 1'b0, 1'b0);
      rd(2'd2, d); check("R10 status set", d, 8'h04);
      measure(10, w, f);
      check("R10 pin idle", w, 0);
      wr(2'd2, 8'h0F);
      wr(2'd1, 8'h00);

      // R8 and R9 stimulus and drive modes
      for (int m = 0; m < 4; m++) begin
         for (int st = 0; st < 2; st++) begin
            int eoe, eout;
            wr(2'd0, cfgb(2'b00, 2'b01, st[0], 2'(m)));
            case (m)
               0: begin eoe = st; eout = 0; end
               1: begin eoe = 1;  eout = 1 - st; end
               2: begin eoe = 1;  eout = st; end
               default: begin eoe = 0; eout = 0; end
            endcase
            check("R9 oe", irq_oe, eoe);
            check("R8 R9 out", irq_out, eout);
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule